// File: doc/BRIEF.md
# Power Button Press Stretcher

This block sits between a debounced, active-low power button and the active-low power button input of a host chipset. The chipset hard-resets once its input has been held low for a fixed time. When the system is running, the block reshapes every press so that this hard reset needs a much longer real press. It forwards a short opening pulse and then releases the chipset input for a fixed gap while the button is still held. If the button is still held after the gap, it drives the chipset input low again until the button is let go. The opening pulse plus the gap add a fixed delay to the chipset's own hold timer.

When the system is running, the block also raises one-cycle strobes toward the host when a press starts and when it ends. When the system is not running, the button level goes straight to the chipset with no reshaping and no strobes. Every duration is a parameter in clock cycles: the opening pulse length and the total offset. The gap is the offset minus the pulse. The parameters default to a 1 MHz timebase: a 32 ms pulse and a 4 s offset.

Top module: `pwrbtn_stretch`

## Requirements
- R1: During and right after reset, `chip_btn_n_o` is high and neither event strobe is asserted.
- R2: While `sys_on_i` is high, `press_evt_o` is high for exactly one cycle. That cycle is the first cycle after the clock edge that samples `btn_n_i` low following a high sample.
- R3: While `sys_on_i` is high, `release_evt_o` is high for exactly one cycle. That cycle is the first cycle after the clock edge that samples `btn_n_i` high following a low sample.
- R4: In running mode, `chip_btn_n_o` goes low in the cycle after the press strobe and stays low for exactly T0_CYCLES cycles if the button stays held.
- R5: After the opening pulse, `chip_btn_n_o` stays high for exactly OFFSET_CYCLES − T0_CYCLES cycles while the button stays held.
- R6: If the button is still held when the gap ends, `chip_btn_n_o` goes low again and stays low until the cycle after the release is sampled.
- R7: A release sampled during the pulse or the gap drives `chip_btn_n_o` high from the next cycle. The remaining phases are abandoned, and a later press starts again with a full opening pulse.
- R8: While `sys_on_i` is low, `chip_btn_n_o` equals the registered button level, one cycle behind `btn_n_i`, and no event strobe is asserted. Dropping `sys_on_i` in the middle of a stretch switches to this pass-through in the same cycle.
- R9: A button already held when `sys_on_i` rises starts no stretch and no press strobe. `chip_btn_n_o` stays high until a fresh press.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_n_i | input | 1 | Debounced power button, low when pressed |
| sys_on_i | input | 1 | High while the system is in its running state |
| chip_btn_n_o | output | 1 | Power button toward the chipset, low when asserted |
| press_evt_o | output | 1 | One-cycle press event toward the host |
| release_evt_o | output | 1 | One-cycle release event toward the host |

## Verification
The bench builds the block with T0_CYCLES = 4 and OFFSET_CYCLES = 11, which gives a 7-cycle gap. With these values, every phase boundary of a press lies within a few tens of cycles. Releases can therefore be placed on the last pulse cycle, inside the gap, and exactly at the gap boundary. A press can also be held well into the re-asserted phase, all in one short run. The same short values let the bench toggle the running mode in the middle of a stretch and hold the button across a mode change. Each of those runs ends long before the watchdog.

// File: rtl/pwrbtn_pkg.sv
package pwrbtn_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PULSE = 2'd1,
    ST_GAP   = 2'd2,
    ST_HOLD  = 2'd3
  } stretch_st_e;

  // length of the forced release gap
  function automatic int unsigned gap_len(input int unsigned offset_c,
                                          input int unsigned t0_c);
    return offset_c - t0_c;
  endfunction

  // width needed to hold the larger of two reload values
  function automatic int unsigned timer_bits(input int unsigned a,
                                             input int unsigned b);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m < 2) ? 1 : $clog2(m);
  endfunction

  // phases in which the chipset sees the button asserted
  function automatic logic phase_asserts(input stretch_st_e st);
    return (st == ST_PULSE) || (st == ST_HOLD);
  endfunction

endpackage

// File: rtl/pb_edge_detect.sv
module pb_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_n_i,
  output logic pressed_o,
  output logic rise_o,
  output logic fall_o
);
  logic pressed_q;
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pressed_q <= 1'b0;
      prev_q    <= 1'b0;
    end else begin
      pressed_q <= ~btn_n_i;
      prev_q    <= pressed_q;
    end
  end

  assign pressed_o = pressed_q;
  assign rise_o    = pressed_q & ~prev_q;
  assign fall_o    = ~pressed_q & prev_q;
endmodule

// File: rtl/pb_phase_timer.sv
module pb_phase_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pb_stretch_fsm.sv
module pb_stretch_fsm
  import pwrbtn_pkg::*;
#(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned T0_LOAD   = 3,
  parameter int unsigned GAP_LOAD  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sys_on_i,
  input  logic             pressed_i,
  input  logic             rise_i,
  input  logic             zero_i,
  output stretch_st_e      st_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o
);
  stretch_st_e st_q, st_d;
  logic        abort;

  assign abort = ~sys_on_i | ~pressed_i;

  always_comb begin
    st_d       = st_q;
    load_o     = 1'b0;
    load_val_o = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (sys_on_i && rise_i) begin
          st_d       = ST_PULSE;
          load_o     = 1'b1;
          load_val_o = CNT_W'(T0_LOAD);
        end
      end
      ST_PULSE: begin
        if (abort) st_d = ST_IDLE;
        else if (zero_i) begin
          st_d       = ST_GAP;
          load_o     = 1'b1;
          load_val_o = CNT_W'(GAP_LOAD);
        end
      end
      ST_GAP: begin
        if (abort)       st_d = ST_IDLE;
        else if (zero_i) st_d = ST_HOLD;
      end
      ST_HOLD: begin
        if (abort) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign st_o = st_q;
endmodule

// File: rtl/pwrbtn_stretch.sv
module pwrbtn_stretch
  import pwrbtn_pkg::*;
#(
  parameter int unsigned T0_CYCLES     = 32000,
  parameter int unsigned OFFSET_CYCLES = 4000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_n_i,
  input  logic sys_on_i,
  output logic chip_btn_n_o,
  output logic press_evt_o,
  output logic release_evt_o
);
  localparam int unsigned T1_CYCLES = gap_len(OFFSET_CYCLES, T0_CYCLES);
  localparam int unsigned CNT_W     = timer_bits(T0_CYCLES, T1_CYCLES);
  localparam int unsigned T0_LOAD   = T0_CYCLES - 1;
  localparam int unsigned GAP_LOAD  = T1_CYCLES - 1;

  logic             pressed_q;
  logic             rise_w;
  logic             fall_w;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_load_val;
  logic [CNT_W-1:0] tmr_cnt;
  logic             tmr_zero;
  stretch_st_e      st_q;

  // named internal events, observed by the checker
  logic pulse_done;
  logic gap_done;
  logic stretch_assert;

  pb_edge_detect u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .btn_n_i   (btn_n_i),
    .pressed_o (pressed_q),
    .rise_o    (rise_w),
    .fall_o    (fall_w)
  );

  pb_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_load_val),
    .cnt_o      (tmr_cnt),
    .zero_o     (tmr_zero)
  );

  pb_stretch_fsm #(
    .CNT_W    (CNT_W),
    .T0_LOAD  (T0_LOAD),
    .GAP_LOAD (GAP_LOAD)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .sys_on_i   (sys_on_i),
    .pressed_i  (pressed_q),
    .rise_i     (rise_w),
    .zero_i     (tmr_zero),
    .st_o       (st_q),
    .load_o     (tmr_load),
    .load_val_o (tmr_load_val)
  );

  assign pulse_done     = (st_q == ST_PULSE) && tmr_zero;
  assign gap_done       = (st_q == ST_GAP) && tmr_zero;
  assign stretch_assert = phase_asserts(st_q);

  assign chip_btn_n_o  = sys_on_i ? ~stretch_assert : ~pressed_q;
  assign press_evt_o   = sys_on_i & rise_w;
  assign release_evt_o = sys_on_i & fall_w;
endmodule

// File: rtl/pwrbtn_stretch_chk.sv
module pwrbtn_stretch_chk
  import pwrbtn_pkg::*;
#(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned MAX_LOAD = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sys_on_i,
  input logic             chip_btn_n_o,
  input logic             press_evt_o,
  input logic             release_evt_o,
  input logic             pressed_q,
  input stretch_st_e      st_q,
  input logic [CNT_W-1:0] tmr_cnt,
  input logic             pulse_done,
  input logic             gap_done
);
  AST_RESET_OUT: assert property (@(posedge clk) !rst_n |-> (chip_btn_n_o || sys_on_i) && !press_evt_o && !release_evt_o); // R1
  AST_PRESS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) press_evt_o |=> !press_evt_o); // R2
  AST_EVT_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(press_evt_o && release_evt_o)); // R3
  AST_PRESS_STARTS_PULSE: assert property (@(posedge clk) disable iff (!rst_n) press_evt_o |=> st_q == ST_PULSE); // R4
  AST_PULSE_TO_GAP: assert property (@(posedge clk) disable iff (!rst_n) (pulse_done && pressed_q && sys_on_i) |=> st_q == ST_GAP); // R5
  AST_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n) tmr_cnt <= CNT_W'(MAX_LOAD)); // R5
  AST_GAP_TO_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (gap_done && pressed_q && sys_on_i) |=> st_q == ST_HOLD); // R6
  AST_RELEASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) release_evt_o |=> st_q == ST_IDLE); // R7
  AST_OFF_NO_EVT: assert property (@(posedge clk) disable iff (!rst_n) !sys_on_i |-> !press_evt_o && !release_evt_o); // R8
  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !sys_on_i |=> st_q == ST_IDLE); // R8
  AST_NO_START_WITHOUT_PRESS: assert property (@(posedge clk) disable iff (!rst_n) ($past(st_q) == ST_IDLE && st_q == ST_PULSE) |-> $past(press_evt_o)); // R9
endmodule

bind pwrbtn_stretch pwrbtn_stretch_chk #(
  .CNT_W    (CNT_W),
  .MAX_LOAD ((T0_LOAD > GAP_LOAD) ? T0_LOAD : GAP_LOAD)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sys_on_i      (sys_on_i),
  .chip_btn_n_o  (chip_btn_n_o),
  .press_evt_o   (press_evt_o),
  .release_evt_o (release_evt_o),
  .pressed_q     (pressed_q),
  .st_q          (st_q),
  .tmr_cnt       (tmr_cnt),
  .pulse_done    (pulse_done),
  .gap_done      (gap_done)
);

// File: tb/test_pwrbtn_stretch.sv
module test_pwrbtn_stretch;
  localparam int T0  = 4;
  localparam int OFS = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic btn_n = 1'b1;
  logic sys_on = 1'b0;
  logic chip_n, p_evt, r_evt;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // behavioural reference state
  bit m_p = 1'b0, m_prev = 1'b0, m_run = 1'b0;
  int m_age = 0;

  always #4 clk = ~clk;

  pwrbtn_stretch #(.T0_CYCLES(T0), .OFFSET_CYCLES(OFS)) i_pwrbtn_stretch (
    .clk           (clk),
    .rst_n         (rst_n),
    .btn_n_i       (btn_n),
    .sys_on_i      (sys_on),
    .chip_btn_n_o  (chip_n),
    .press_evt_o   (p_evt),
    .release_evt_o (r_evt)
  );

  task automatic model_edge();
    bit old_p, old_prev;
    old_p = m_p; old_prev = m_prev;
    if (!rst_n) begin
      m_p = 0; m_prev = 0; m_run = 0; m_age = 0;
      return;
    end
    if (!sys_on || !old_p) m_run = 0;
    else if (m_run) m_age++;
    else if (!old_prev) begin m_run = 1; m_age = 0; end
    m_prev = old_p;
    m_p    = ~btn_n;
  endtask

  task automatic check1(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare(string req);
    logic e_chip, e_p, e_r, asserting;
    asserting = m_run && (m_age < T0 || m_age >= OFS);
    e_chip = sys_on ? ~asserting : ~m_p;
    e_p    = sys_on & m_p & ~m_prev;
    e_r    = sys_on & ~m_p & m_prev;
    check1(req, "chip_btn_n", chip_n, e_chip);
    check1(req, "press_evt", p_evt, e_p);
    check1(req, "release_evt", r_evt, e_r);
  endtask

  task automatic run(bit pressed, bit on, int n, string req);
    for (int i = 0; i < n; i++) begin
      btn_n  = ~pressed;
      sys_on = on;
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare(req);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) begin
      @(posedge clk); model_edge(); @(negedge clk);
      check1("R1", "chip_btn_n in reset", chip_n, 1'b1);
      check1("R1", "press_evt in reset", p_evt, 1'b0);
      check1("R1", "release_evt in reset", r_evt, 1'b0);
    end
    rst_n = 1'b1;
    run(0, 1, 3, "R1");

    // R2 R3 R7: tap released inside the pulse
    run(1, 1, 2, "R2");
    run(0, 1, 4, "R3");
    // R7: release on last pulse cycle
    run(1, 1, T0, "R7");
    run(0, 1, 4, "R7");

    // R4 R5 R6: long press into re-assertion
    run(1, 1, 1, "R4");
    run(1, 1, T0, "R4");
    run(1, 1, OFS - T0, "R5");
    run(1, 1, 12, "R6");
    run(0, 1, 4, "R6");

    // R7: release in the middle of the gap, then a fresh full press
    run(1, 1, T0 + 3, "R7");
    run(0, 1, 3, "R7");
    run(1, 1, OFS + 3, "R7");
    run(0, 1, 3, "R7");

    // R6 boundary: release right at the gap end
    run(1, 1, OFS + 1, "R6");
    run(0, 1, 3, "R6");

    // R8: not running, pass-through without events
    run(1, 0, 20, "R8");
    run(0, 0, 3, "R8");
    run(1, 0, 2, "R8");
    run(0, 0, 2, "R8");

    // R9: held across the rise of sys_on
    run(1, 0, 3, "R9");
    run(1, 1, 20, "R9");
    run(0, 1, 3, "R9");

    // R8: running mode dropped while in the re-asserted phase and in the gap
    run(1, 1, OFS + 4, "R8");
    run(1, 0, 4, "R8");
    run(0, 0, 2, "R8");
    run(1, 1, T0 + 2, "R8");
    run(1, 0, 3, "R8");
    run(0, 1, 3, "R8");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule